// File: doc/BRIEF.md
# Indirect Banked Register Access Port

This block is an 8-bit host-bus slave that reaches a banked register file through a single address line. With `cmd_sel` high the host talks to the command port; with it low, to the data port. Command-port writes load a 5-bit bank pointer or a 5-bit register pointer, and the top three bits of the byte choose which. Command-port reads return a status byte at once, with no pointer setup.

Data-port accesses work on the register that the two pointers select. Registers four or six bytes wide pass through a holding register. The first read takes a snapshot of the whole value, and later reads return its bytes least significant first. A six-byte writable register takes its new value only once six consecutive data writes have arrived.

The strobes and chip select are asynchronous. They pass through two-flop synchronizers and are turned into edges in the core clock domain. A ready line drops as soon as a strobe is asserted and rises again once the access has been serviced. The attribute counters are stubs: each is a 32-bit counter advanced by one bit of `evt`.

Top module: `idx_reg_port`

## Requirements
- R1: A command-port write of `000bbbbb` loads the bank pointer with `bbbbb`, and `111rrrrr` loads the register pointer with `rrrrr`. The two may come in either order, and a pointer that is not written keeps its value.
- R2: A command-port write whose top three bits are neither 000 nor 111 leaves both pointers unchanged.
- R3: A command-port read returns `{err_flag, irq_flag, match_flag, 5'b00000}` (bit 7 down to bit 0).
- R4: Register map: bank 0 register 0 is a one-byte read/write setup byte, bank 0 register 1 is a six-byte read/write match register, bank `CNT_BANK` (default 1) registers 0 to `NUM_CNT-1` are four-byte read-only counters (counter i advances on `evt[i]`), and everything else reads 0x00. The first data read of a multi-byte register snapshots it, and later reads return the snapshot's bytes least significant first, whatever the live value does meanwhile.
- R5: After the last byte of a multi-byte register has been read, the next data read takes a fresh snapshot and returns its least significant byte.
- R6: Any command-port write restarts the data read sequence at the least significant byte.
- R7: The six-byte match register takes its value only on the sixth consecutive data write, bytes least significant first. A command-port write before the sixth write discards the partial bytes and leaves the stored value unchanged.
- R8: The one-byte setup register is read and written directly. Data writes to the read-only counters are ignored.
- R9: `rdy` is high when idle, goes low as soon as chip select and a strobe are both low, and rises within 12 clock cycles while the strobe is held.
- R10: Strobes while `cs_n` is high have no effect and leave `rdy` high. Holding `cs_n` low all the time across many accesses works.
- R11: `dout_oe` is high only while `cs_n` and `rd_n` are both low.
- R12: After reset both pointers, the setup byte, the match register and all counters are zero, `rdy` is high and `dout_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| cmd_sel | input | 1 | 1 selects the command port, 0 the data port |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; data taken while held |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data to the host |
| dout_oe | output | 1 | Output enable for the host data pins |
| rdy | output | 1 | Ready, low while an access is pending |
| err_flag | input | 1 | Interface error flag for the status byte |
| irq_flag | input | 1 | Interrupt output state for the status byte |
| match_flag | input | 1 | Source-address match flag for the status byte |
| evt | input | NUM_CNT | Per-counter increment pulses for the stub counters |

## Verification
The bench advances a counter between reads of one sequence. A design that copied live bytes instead of a snapshot would return a mixed value, and one that failed to re-snapshot after the last byte would replay stale data. It interrupts a six-byte write with a command write and then writes six fresh bytes. An early commit, or a write byte counter that is not cleared, would show up as corrupted match bytes. It also sends a command byte with an illegal prefix, strobes with chip select high, and runs with chip select tied low. These catch pointer corruption, ungated strobes, and ready timing that depends on chip select edges.

// File: rtl/ixp_pkg.sv
package ixp_pkg;
  localparam int BYTE_W     = 8;
  localparam int PTR_W      = 5;
  localparam int WIDE_BYTES = 6;
  localparam int QUAD_BYTES = 4;
  localparam int VAL_W      = WIDE_BYTES * BYTE_W;
  localparam int IDX_W      = 3;

  // fixed locations inside bank 0
  localparam logic [PTR_W-1:0] SYS_BANK  = 5'd0;
  localparam logic [PTR_W-1:0] SETUP_REG = 5'd0;
  localparam logic [PTR_W-1:0] MATCH_REG = 5'd1;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_BYTE = 2'd1,
    K_QUAD = 2'd2,
    K_WIDE = 2'd3
  } kind_e;

  function automatic logic [IDX_W-1:0] kind_len(kind_e k);
    case (k)
      K_QUAD:  kind_len = IDX_W'(QUAD_BYTES);
      K_WIDE:  kind_len = IDX_W'(WIDE_BYTES);
      default: kind_len = IDX_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/ixp_sync.sv
module ixp_sync #(
  parameter int             N       = 4,
  parameter logic [N-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  for (genvar g = 0; g < N; g++) begin : gen_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
      end
    end
    assign sync_o[g] = stab_q;
  end
endmodule

// File: rtl/ixp_attr.sv
module ixp_attr
  import ixp_pkg::*;
#(
  parameter int NUM_CNT  = 4,
  parameter int CNT_W    = 32,
  parameter int CNT_BANK = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CNT-1:0]  evt,
  input  logic [PTR_W-1:0]    bank,
  input  logic [PTR_W-1:0]    regn,
  input  logic                wr1_en,
  input  logic [BYTE_W-1:0]   wr1_data,
  input  logic                wr6_en,
  input  logic [VAL_W-1:0]    wr6_data,
  output kind_e               kind,
  output logic [VAL_W-1:0]    value
);
  logic [BYTE_W-1:0] setup_q, setup_d;
  logic [VAL_W-1:0]  match_q, match_d;
  logic [CNT_W-1:0]  cnt_q [NUM_CNT];
  logic [CNT_W-1:0]  cnt_d [NUM_CNT];

  // decode of the selected location
  always_comb begin
    kind  = K_NONE;
    value = '0;
    if (bank == SYS_BANK && regn == SETUP_REG) begin
      kind  = K_BYTE;
      value = VAL_W'(setup_q);
    end else if (bank == SYS_BANK && regn == MATCH_REG) begin
      kind  = K_WIDE;
      value = match_q;
    end else if (bank == PTR_W'(CNT_BANK)) begin
      for (int i = 0; i < NUM_CNT; i++) begin
        if (regn == PTR_W'(i)) begin
          kind  = K_QUAD;
          value = VAL_W'(cnt_q[i]);
        end
      end
    end
  end

  always_comb begin
    setup_d = setup_q;
    match_d = match_q;
    if (wr1_en && kind == K_BYTE) setup_d = wr1_data;
    if (wr6_en && kind == K_WIDE) match_d = wr6_data;
    for (int i = 0; i < NUM_CNT; i++)
      cnt_d[i] = evt[i] ? cnt_q[i] + 1'b1 : cnt_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= '0;
      match_q <= '0;
      for (int i = 0; i < NUM_CNT; i++) cnt_q[i] <= '0;
    end else begin
      setup_q <= setup_d;
      match_q <= match_d;
      for (int i = 0; i < NUM_CNT; i++) cnt_q[i] <= cnt_d[i];
    end
  end

  // R7: the match register only moves on a six-byte commit
  assert_match_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(match_q) |-> $past(wr6_en));

  for (genvar g = 0; g < NUM_CNT; g++) begin : gen_cnt_chk
    // R4: stub counters step by exactly one per event
    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      evt[g] |=> (cnt_q[g] == $past(cnt_q[g]) + 1'b1));
  end
endmodule

// File: rtl/ixp_seq.sv
module ixp_seq
  import ixp_pkg::*;
#(
  parameter int WAIT_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              rd_s,
  input  logic              wr_s,
  input  logic              cmd_s,
  input  logic [BYTE_W-1:0] din,
  input  logic [2:0]        stat,
  input  kind_e             kind,
  input  logic [VAL_W-1:0]  value,
  output logic [PTR_W-1:0]  bank_ptr,
  output logic [PTR_W-1:0]  reg_ptr,
  output logic [BYTE_W-1:0] dout,
  output logic              done,
  output logic              wr1_en,
  output logic [BYTE_W-1:0] wr1_data,
  output logic              wr6_en,
  output logic [VAL_W-1:0]  wr6_data
);
  localparam int WT_W  = $clog2(WAIT_CYC + 1);
  localparam int BUF_W = (WIDE_BYTES - 1) * BYTE_W;

  logic              rd_act, wr_act, rd_start, wr_start, rd_end, wr_end, acc_start;
  logic              rd_act_q, wr_act_q, acc_cmd_q, acc_cmd_d;
  logic [BYTE_W-1:0] din_q, din_d, dout_q, dout_d;
  logic [PTR_W-1:0]  bank_q, bank_d, reg_q, reg_d;
  logic [IDX_W-1:0]  rd_idx_q, rd_idx_d, wr_idx_q, wr_idx_d;
  logic              live_q, live_d;
  logic [VAL_W-1:0]  hold_q, hold_d;
  logic [BUF_W-1:0]  wbuf_q, wbuf_d;
  logic [WT_W-1:0]   wait_q, wait_d;
  logic              done_q, done_d;
  logic              multi;

  assign rd_act    = !cs_s && !rd_s;
  assign wr_act    = !cs_s && !wr_s;
  assign rd_start  = rd_act && !rd_act_q;
  assign wr_start  = wr_act && !wr_act_q;
  assign rd_end    = !rd_act && rd_act_q;
  assign wr_end    = !wr_act && wr_act_q;
  assign acc_start = rd_start || wr_start;
  assign multi     = (kind == K_QUAD) || (kind == K_WIDE);

  always_comb begin
    acc_cmd_d = acc_start ? cmd_s : acc_cmd_q;
    din_d     = wr_act ? din : din_q;
    dout_d    = dout_q;
    bank_d    = bank_q;
    reg_d     = reg_q;
    rd_idx_d  = rd_idx_q;
    wr_idx_d  = wr_idx_q;
    live_d    = live_q;
    hold_d    = hold_q;
    wbuf_d    = wbuf_q;
    wr1_en    = 1'b0;
    wr6_en    = 1'b0;
    wr1_data  = din_q;
    wr6_data  = {din_q, wbuf_q};

    // read service at the start of the strobe
    if (rd_start) begin
      if (cmd_s) begin
        dout_d = {stat, 5'b00000};
      end else if (kind == K_BYTE) begin
        dout_d = value[BYTE_W-1:0];
      end else if (multi) begin
        if (live_q) begin
          for (int b = 0; b < WIDE_BYTES; b++)
            if (rd_idx_q == IDX_W'(b)) dout_d = hold_q[b*BYTE_W +: BYTE_W];
        end else begin
          hold_d   = value;
          live_d   = 1'b1;
          rd_idx_d = '0;
          dout_d   = value[BYTE_W-1:0];
        end
      end else begin
        dout_d = '0;
      end
    end

    // read sequence advances when the strobe is released
    if (rd_end && !acc_cmd_q && live_q && multi) begin
      if (rd_idx_q == kind_len(kind) - 1'b1) begin
        live_d   = 1'b0;
        rd_idx_d = '0;
      end else begin
        rd_idx_d = rd_idx_q + 1'b1;
      end
    end

    // writes act when the strobe is released
    if (wr_end) begin
      if (acc_cmd_q) begin
        if (din_q[7:5] == 3'b000)      bank_d = din_q[PTR_W-1:0];
        else if (din_q[7:5] == 3'b111) reg_d  = din_q[PTR_W-1:0];
        live_d   = 1'b0;
        rd_idx_d = '0;
        wr_idx_d = '0;
      end else if (kind == K_BYTE) begin
        wr1_en = 1'b1;
      end else if (kind == K_WIDE) begin
        if (wr_idx_q == IDX_W'(WIDE_BYTES - 1)) begin
          wr6_en   = 1'b1;
          wr_idx_d = '0;
        end else begin
          for (int b = 0; b < WIDE_BYTES - 1; b++)
            if (wr_idx_q == IDX_W'(b)) wbuf_d[b*BYTE_W +: BYTE_W] = din_q;
          wr_idx_d = wr_idx_q + 1'b1;
        end
      end
    end

    // ready pacing
    if (acc_start)                       wait_d = WT_W'(WAIT_CYC);
    else if ((rd_act || wr_act) && wait_q != '0) wait_d = wait_q - 1'b1;
    else                                 wait_d = wait_q;
    done_d = (rd_act || wr_act) && !acc_start && (wait_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q  <= 1'b0;
      wr_act_q  <= 1'b0;
      acc_cmd_q <= 1'b0;
      din_q     <= '0;
      dout_q    <= '0;
      bank_q    <= '0;
      reg_q     <= '0;
      rd_idx_q  <= '0;
      wr_idx_q  <= '0;
      live_q    <= 1'b0;
      hold_q    <= '0;
      wbuf_q    <= '0;
      wait_q    <= '0;
      done_q    <= 1'b0;
    end else begin
      rd_act_q  <= rd_act;
      wr_act_q  <= wr_act;
      acc_cmd_q <= acc_cmd_d;
      din_q     <= din_d;
      dout_q    <= dout_d;
      bank_q    <= bank_d;
      reg_q     <= reg_d;
      rd_idx_q  <= rd_idx_d;
      wr_idx_q  <= wr_idx_d;
      live_q    <= live_d;
      hold_q    <= hold_d;
      wbuf_q    <= wbuf_d;
      wait_q    <= wait_d;
      done_q    <= done_d;
    end
  end

  assign bank_ptr = bank_q;
  assign reg_ptr  = reg_q;
  assign dout     = dout_q;
  assign done     = done_q;

  // R1: a 000-prefixed command byte lands in the bank pointer
  assert_bank_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_end && acc_cmd_q && din_q[7:5] == 3'b000) |=> (bank_q == $past(din_q[PTR_W-1:0])));
  // R2: an illegal prefix leaves both pointers alone
  assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_end && acc_cmd_q && din_q[7:5] != 3'b000 && din_q[7:5] != 3'b111)
      |=> ($stable(bank_q) && $stable(reg_q)));
  // R6: a command write restarts the read sequence
  assert_seq_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_end && acc_cmd_q) |=> (rd_idx_q == '0 && !live_q));
  // R5: byte index never runs past the widest register
  assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx_q < IDX_W'(WIDE_BYTES));
  // R9: completion only reported while a strobe is seen
  assert_done_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(rd_act) || $past(wr_act)));
endmodule

// File: rtl/idx_reg_port.sv
module idx_reg_port
  import ixp_pkg::*;
#(
  parameter int NUM_CNT  = 4,
  parameter int CNT_W    = 32,
  parameter int CNT_BANK = 1,
  parameter int WAIT_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               cmd_sel,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic [7:0]         din,
  output logic [7:0]         dout,
  output logic               dout_oe,
  output logic               rdy,
  input  logic               err_flag,
  input  logic               irq_flag,
  input  logic               match_flag,
  input  logic [NUM_CNT-1:0] evt
);
  logic [3:0]        sync_v;
  logic [PTR_W-1:0]  bank_ptr, reg_ptr;
  kind_e             kind;
  logic [VAL_W-1:0]  value;
  logic              done;
  logic              wr1_en, wr6_en;
  logic [BYTE_W-1:0] wr1_data;
  logic [VAL_W-1:0]  wr6_data;
  logic              strobe_raw;

  ixp_sync #(.N(4), .RST_VAL(4'b1111)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({cmd_sel, wr_n, rd_n, cs_n}),
    .sync_o  (sync_v)
  );

  ixp_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (sync_v[0]),
    .rd_s     (sync_v[1]),
    .wr_s     (sync_v[2]),
    .cmd_s    (sync_v[3]),
    .din      (din),
    .stat     ({err_flag, irq_flag, match_flag}),
    .kind     (kind),
    .value    (value),
    .bank_ptr (bank_ptr),
    .reg_ptr  (reg_ptr),
    .dout     (dout),
    .done     (done),
    .wr1_en   (wr1_en),
    .wr1_data (wr1_data),
    .wr6_en   (wr6_en),
    .wr6_data (wr6_data)
  );

  ixp_attr #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .CNT_BANK(CNT_BANK)) u_attr (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .bank     (bank_ptr),
    .regn     (reg_ptr),
    .wr1_en   (wr1_en),
    .wr1_data (wr1_data),
    .wr6_en   (wr6_en),
    .wr6_data (wr6_data),
    .kind     (kind),
    .value    (value)
  );

  // chip select gates the strobes before they reach the pins' handshake
  assign strobe_raw = !cs_n && (!rd_n || !wr_n);
  assign rdy        = !strobe_raw || done;
  assign dout_oe    = !cs_n && !rd_n;
endmodule

// File: tb/idx_reg_port_tb.sv
module idx_reg_port_tb;
  localparam int CLK_P = 10;
  localparam int NV    = 42;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, cmd_sel = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_oe, rdy;
  logic       err_flag = 1'b0, irq_flag = 1'b0, match_flag = 1'b0;
  logic [3:0] evt = '0;

  int checks = 0, errors = 0;
  bit cs_tie = 1'b0, fin = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  idx_reg_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_sel(cmd_sel), .rd_n(rd_n),
    .wr_n(wr_n), .din(din), .dout(dout), .dout_oe(dout_oe), .rdy(rdy),
    .err_flag(err_flag), .irq_flag(irq_flag), .match_flag(match_flag), .evt(evt)
  );

  // {req, read, cmd, data, expect}
  localparam logic [21:0] VEC [NV] = '{
    {4'd1, 1'b0, 1'b1, 8'h00, 8'h00},  // R1 bank 0
    {4'd1, 1'b0, 1'b1, 8'hE0, 8'h00},  // R1 reg 0 (setup byte)
    {4'd8, 1'b0, 1'b0, 8'h5A, 8'h00},  // R8 direct byte write
    {4'd8, 1'b1, 1'b0, 8'h00, 8'h5A},  // R8 direct byte read
    {4'd1, 1'b0, 1'b1, 8'hE1, 8'h00},  // R1 reg 1, bank kept
    {4'd7, 1'b0, 1'b0, 8'h11, 8'h00},  // R7 six-byte write
    {4'd7, 1'b0, 1'b0, 8'h22, 8'h00},
    {4'd7, 1'b0, 1'b0, 8'h33, 8'h00},
    {4'd7, 1'b0, 1'b0, 8'h44, 8'h00},
    {4'd7, 1'b0, 1'b0, 8'h55, 8'h00},
    {4'd7, 1'b0, 1'b0, 8'h66, 8'h00},
    {4'd4, 1'b1, 1'b0, 8'h00, 8'h11},  // R4 LSB first
    {4'd4, 1'b1, 1'b0, 8'h00, 8'h22},
    {4'd4, 1'b1, 1'b0, 8'h00, 8'h33},
    {4'd4, 1'b1, 1'b0, 8'h00, 8'h44},
    {4'd4, 1'b1, 1'b0, 8'h00, 8'h55},
    {4'd4, 1'b1, 1'b0, 8'h00, 8'h66},
    {4'd5, 1'b1, 1'b0, 8'h00, 8'h11},  // R5 wrap to LSB
    {4'd5, 1'b1, 1'b0, 8'h00, 8'h22},
    {4'd6, 1'b0, 1'b1, 8'hE1, 8'h00},  // R6 command restarts
    {4'd6, 1'b1, 1'b0, 8'h00, 8'h11},
    {4'd7, 1'b0, 1'b0, 8'hAA, 8'h00},  // R7 partial write
    {4'd7, 1'b0, 1'b0, 8'hBB, 8'h00},
    {4'd7, 1'b0, 1'b0, 8'hCC, 8'h00},
    {4'd7, 1'b0, 1'b0, 8'hDD, 8'h00},
    {4'd7, 1'b0, 1'b0, 8'hEE, 8'h00},
    {4'd7, 1'b0, 1'b1, 8'hE1, 8'h00},  // R7 abort
    {4'd7, 1'b1, 1'b0, 8'h00, 8'h11},
    {4'd7, 1'b1, 1'b0, 8'h00, 8'h22},
    {4'd7, 1'b0, 1'b1, 8'hE1, 8'h00},
    {4'd7, 1'b0, 1'b0, 8'h01, 8'h00},  // R7 fresh count after abort
    {4'd7, 1'b0, 1'b0, 8'h02, 8'h00},
    {4'd7, 1'b0, 1'b0, 8'h03, 8'h00},
    {4'd7, 1'b0, 1'b0, 8'h04, 8'h00},
    {4'd7, 1'b0, 1'b0, 8'h05, 8'h00},
    {4'd7, 1'b0, 1'b0, 8'h06, 8'h00},
    {4'd7, 1'b1, 1'b0, 8'h00, 8'h01},
    {4'd7, 1'b1, 1'b0, 8'h00, 8'h02},
    {4'd2, 1'b0, 1'b1, 8'h42, 8'h00},  // R2 illegal prefix
    {4'd2, 1'b1, 1'b0, 8'h00, 8'h01},
    {4'd1, 1'b0, 1'b1, 8'hE0, 8'h00},  // R1 back to setup byte
    {4'd1, 1'b1, 1'b0, 8'h00, 8'h5A}
  };

  task automatic chk(input int req, input logic [7:0] got, input logic [7:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  // one host access; R9 ready and R11 output enable checked on each
  task automatic acc(input bit rd, input bit c, input logic [7:0] d, output logic [7:0] q);
    int n;
    @(negedge clk);
    cmd_sel = c; din = d; cs_n = 1'b0;
    if (rd) rd_n = 1'b0; else wr_n = 1'b0;
    #1;
    chk(9, 8'(rdy), 8'h00, "rdy low at strobe");
    n = 0;
    while (!rdy && n < 20) begin @(negedge clk); n++; end
    chk(9, 8'(n <= 12), 8'h01, "rdy released in time");
    q = dout;
    if (rd) chk(11, 8'(dout_oe), 8'h01, "oe during read");
    rd_n = 1'b1; wr_n = 1'b1;
    if (!cs_tie) cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic wr(input bit c, input logic [7:0] d);
    logic [7:0] q;
    acc(1'b0, c, d, q);
  endtask

  task automatic rdchk(input bit c, input logic [7:0] exp, input int req, input string what);
    logic [7:0] q;
    acc(1'b1, c, 8'h00, q);
    chk(req, q, exp, what);
  endtask

  task automatic pulse(input int idx, input int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk); evt[idx] = 1'b1;
      @(negedge clk); evt[idx] = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    chk(12, 8'(rdy), 8'h01, "rdy idle after reset");
    chk(12, 8'(dout_oe), 8'h00, "oe idle after reset");
    rdchk(1'b0, 8'h00, 12, "setup byte after reset");
    chk(11, 8'(dout_oe), 8'h00, "oe off after read");
    rdchk(1'b1, 8'h00, 3, "status with flags clear");

    // vector table
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][17]) rdchk(VEC[v][16], VEC[v][7:0], int'(VEC[v][21:18]), "table read");
      else            wr(VEC[v][16], VEC[v][15:8]);
    end

    // R3 status byte bits
    err_flag = 1'b1; match_flag = 1'b1;
    rdchk(1'b1, 8'hA0, 3, "status err+match");
    err_flag = 1'b0; match_flag = 1'b0; irq_flag = 1'b1;
    rdchk(1'b1, 8'h40, 3, "status irq");
    irq_flag = 1'b0;

    // R4 snapshot, R5 resnapshot on counter 2
    wr(1'b1, 8'hE2);
    wr(1'b1, 8'h01);
    pulse(2, 300);                         // 0x12C
    rdchk(1'b0, 8'h2C, 4, "counter byte0");
    pulse(2, 256);                         // live 0x22C
    rdchk(1'b0, 8'h01, 4, "counter byte1 from snapshot");
    rdchk(1'b0, 8'h00, 4, "counter byte2");
    rdchk(1'b0, 8'h00, 4, "counter byte3");
    rdchk(1'b0, 8'h2C, 5, "resnapshot byte0");
    rdchk(1'b0, 8'h02, 5, "resnapshot byte1");

    // R8 write to read-only counter ignored
    wr(1'b0, 8'hFF);
    wr(1'b1, 8'hE2);
    rdchk(1'b0, 8'h2C, 8, "counter after ignored write b0");
    rdchk(1'b0, 8'h02, 8, "counter after ignored write b1");
    wr(1'b1, 8'hE3);
    rdchk(1'b0, 8'h00, 4, "other counter untouched");

    // R10 strobe with chip select high has no effect
    wr(1'b1, 8'h00);
    wr(1'b1, 8'hE0);
    @(negedge clk);
    cmd_sel = 1'b0; din = 8'h77; wr_n = 1'b0;
    #1 chk(10, 8'(rdy), 8'h01, "rdy high when deselected");
    repeat (10) @(negedge clk);
    wr_n = 1'b1;
    repeat (5) @(negedge clk);
    rdchk(1'b0, 8'h5A, 10, "setup unchanged without cs");

    // R10 chip select tied low
    cs_tie = 1'b1; cs_n = 1'b0;
    repeat (4) @(negedge clk);
    wr(1'b0, 8'h3C);
    rdchk(1'b0, 8'h3C, 10, "setup with cs tied low");
    wr(1'b1, 8'hE1);
    rdchk(1'b0, 8'h01, 10, "wide byte0 with cs tied low");
    cs_tie = 1'b0; cs_n = 1'b1;

    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule